// File: doc/BRIEF.md
# Parallel Sample Packing Unit

This block accepts samples from a parallel input port and merges bit slices of consecutive samples into 32-bit words for a downstream FIFO or DMA path. A static mode input selects one of two packings. In trio mode three samples form one word, with the upper 10, 11 and 11 bits of the samples placed from the least significant end upward. In pair mode two samples form one word, each contributing its upper 16 bits.

A hold input stalls acquisition for the current cycle. A combinational strobe output marks every cycle in which a sample is taken. The pack position advances only on those accepted cycles. A completed word is presented as a one-cycle valid pulse. If the downstream ready is low during that pulse, a sticky overflow flag is raised. Dropping the enable input, or changing the mode, throws away any partially built word. Packing then restarts at the first slice position.

Top module: `smp_pack_top`

## Requirements
- R1: `strobe` is high in exactly those cycles where `enable` is 1 and `hold` is 0, with no register delay. A sample is accepted on the rising edge that ends such a cycle.
- R2: With `mode_trio` = 1, three accepted samples s0, s1, s2 form the word `{s2[19:9], s1[19:9], s0[19:10]}`. Bits 9:0 come from s0, bits 20:10 from s1 and bits 31:21 from s2.
- R3: With `mode_trio` = 0, two accepted samples s0, s1 form the word `{s1[19:4], s0[19:4]}`.
- R4: `word_valid` is high for exactly one cycle: the cycle right after the edge that accepts the final sample of a group. `word_data` carries the word in that cycle. No word is produced otherwise.
- R5: A cycle with `hold` = 1 accepts no sample and leaves the pack position unchanged.
- R6: While `enable` = 0, no sample is accepted and no strobe is given. Any partially built word is discarded, and packing resumes at the first position.
- R7: A change of `mode_trio` from one cycle to the next discards the partial word. The sample in the cycle of the change, if accepted, becomes the first slice of the new mode.
- R8: `overflow` is set in the cycle after any cycle with `word_valid` = 1 and `word_ready` = 0. Once set, it stays set until reset.
- R9: After reset, `word_valid` and `overflow` are 0 and the pack position is the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; low discards partial word |
| mode_trio | input | 1 | 1 = three samples per word, 0 = two samples per word |
| hold | input | 1 | Stall acquisition for this cycle |
| sample_in | input | SAMPLE_W (20) | Parallel input sample |
| strobe | output | 1 | Sample taken in this cycle |
| word_valid | output | 1 | One-cycle pulse: packed word available |
| word_data | output | WORD_W (32) | Packed word |
| word_ready | input | 1 | Downstream can take the word |
| overflow | output | 1 | Sticky: a word was offered while not ready |

## Verification
The strobe depends only on the current inputs, so it is checked 1 ns after the driver changes them in the same cycle. A packed word is due one register stage after the edge that accepts its final sample. The driver changes inputs 2 ns after each rising edge and queues the expected word as soon as it drives the final accepted sample. A monitor pops one entry at every falling edge where `word_valid` is high. Overflow lags one more edge behind, so the monitor compares it against an expectation it updates only after each falling-edge comparison. A word left in the queue at the end counts as a missing result.

// File: rtl/smp_pack_pkg.sv
package smp_pack_pkg;

   typedef enum logic {
      PACK_PAIR = 1'b0,
      PACK_TRIO = 1'b1
   } pack_mode_e;

   // position counter width: enough for three slice positions
   localparam int POS_W = 2;

endpackage

// File: rtl/smp_slice_map.sv
module smp_slice_map
   import smp_pack_pkg::*;
#(
   parameter int SAMPLE_W = 20,
   parameter int WORD_W   = 32
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  pack_mode_e          mode,
   input  logic [POS_W-1:0]    pos,
   output logic [WORD_W-1:0]   slice
);

   // trio slices: the short one first, the two long ones above it
   localparam int TRI_W0  = WORD_W / 3;
   localparam int TRI_W1  = (WORD_W - TRI_W0) / 2;
   localparam int TRI_W2  = WORD_W - TRI_W0 - TRI_W1;
   localparam int PAIR_W0 = WORD_W / 2;
   localparam int PAIR_W1 = WORD_W - PAIR_W0;

   generate
      if (SAMPLE_W < TRI_W2 || SAMPLE_W < PAIR_W1) begin : g_bad_width
         $error("smp_slice_map: SAMPLE_W too narrow for the widest slice");
      end
      if (TRI_W1 != TRI_W2 && TRI_W2 != TRI_W1 + 1) begin : g_bad_split
         $error("smp_slice_map: unexpected trio split");
      end
   endgenerate

   always_comb begin
      slice = '0;
      if (mode == PACK_TRIO) begin
         if (pos == POS_W'(0))
            slice = WORD_W'(sample[SAMPLE_W-1 -: TRI_W0]);
         else if (pos == POS_W'(1))
            slice = WORD_W'(sample[SAMPLE_W-1 -: TRI_W1]) << TRI_W0;
         else
            slice = WORD_W'(sample[SAMPLE_W-1 -: TRI_W2]) << (TRI_W0 + TRI_W1);
      end else begin
         if (pos == POS_W'(0))
            slice = WORD_W'(sample[SAMPLE_W-1 -: PAIR_W0]);
         else
            slice = WORD_W'(sample[SAMPLE_W-1 -: PAIR_W1]) << PAIR_W0;
      end
   end

endmodule

// File: rtl/smp_pack_ctrl.sv
module smp_pack_ctrl
   import smp_pack_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             hold,
   input  pack_mode_e       mode,
   output logic             accept,
   output logic             restart,
   output logic             last,
   output logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] TRI_LAST  = POS_W'(2);
   localparam logic [POS_W-1:0] PAIR_LAST = POS_W'(1);

   generate
      if (POS_W < 2) begin : g_bad_pos
         $error("smp_pack_ctrl: position counter too narrow");
      end
   endgenerate

   pack_mode_e       mode_q;
   logic [POS_W-1:0] pos_q;

   assign accept  = enable & ~hold;
   assign restart = (mode != mode_q);
   assign pos     = restart ? '0 : pos_q;
   assign last    = (pos == ((mode == PACK_TRIO) ? TRI_LAST : PAIR_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= PACK_TRIO;
         pos_q  <= '0;
      end else begin
         mode_q <= mode;
         if (!enable)
            pos_q <= '0;
         else if (accept)
            pos_q <= last ? '0 : pos + POS_W'(1);
         else
            pos_q <= pos;
      end
   end

   // R5: a held cycle keeps the position
   a_r5_hold_keeps_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && hold && !restart) |=> (pos_q == $past(pos_q)));

   // R6: disable returns to the first position
   a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (pos_q == '0));

   // R7: an accepted sample on a mode change is the first slice
   a_r7_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && accept) |=> (pos_q == POS_W'(1)));

   // R3: pair mode never reaches a third position
   a_r3_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PACK_PAIR) |-> (pos_q <= PAIR_LAST));

endmodule

// File: rtl/smp_pack_top.sv
module smp_pack_top #(
   parameter int SAMPLE_W = 20,
   parameter int WORD_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                mode_trio,
   input  logic                hold,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic                strobe,
   output logic                word_valid,
   output logic [WORD_W-1:0]   word_data,
   input  logic                word_ready,
   output logic                overflow
);
   import smp_pack_pkg::*;

   generate
      if (WORD_W < 6) begin : g_bad_word
         $error("smp_pack_top: WORD_W too small to pack");
      end
   endgenerate

   pack_mode_e       mode;
   logic             accept;
   logic             restart;
   logic             last;
   logic [POS_W-1:0] pos;
   logic [WORD_W-1:0] slice;
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] acc_base;

   assign mode = pack_mode_e'(mode_trio);

   smp_pack_ctrl i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .hold    (hold),
      .mode    (mode),
      .accept  (accept),
      .restart (restart),
      .last    (last),
      .pos     (pos)
   );

   smp_slice_map #(
      .SAMPLE_W (SAMPLE_W),
      .WORD_W   (WORD_W)
   ) i_map (
      .sample (sample_in),
      .mode   (mode),
      .pos    (pos),
      .slice  (slice)
   );

   assign strobe   = accept;
   assign acc_base = restart ? '0 : acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         word_data  <= '0;
         word_valid <= 1'b0;
         overflow   <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (word_valid && !word_ready)
            overflow <= 1'b1;
         if (!enable) begin
            acc_q <= '0;
         end else if (accept) begin
            if (last) begin
               word_data  <= acc_base | slice;
               word_valid <= 1'b1;
               acc_q      <= '0;
            end else begin
               acc_q <= acc_base | slice;
            end
         end else if (restart) begin
            acc_q <= '0;
         end
      end
   end

   // R4: a word only follows an accepted sample
   a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(strobe));

   // R4: the valid pulse lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R6: no word while disabled
   a_r6_no_word_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !word_valid);

   // R8: refused word raises overflow
   a_r8_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_ready) |=> overflow);

   // R8: overflow is sticky
   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

endmodule

// File: tb/test_smp_pack_top.sv
module test_smp_pack_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enable;
   logic        mode_trio;
   logic        hold;
   logic [19:0] sample_in;
   logic        strobe;
   logic        word_valid;
   logic [31:0] word_data;
   logic        word_ready;
   logic        overflow;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [19:0] grp[$];
   logic        prev_mode = 1'b1;
   logic        exp_ovf   = 1'b0;
   logic        mon_on    = 1'b0;
   logic        done      = 1'b0;

   always #5 clk = ~clk;

   smp_pack_top i_smp_pack_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .mode_trio  (mode_trio),
      .hold       (hold),
      .sample_in  (sample_in),
      .strobe     (strobe),
      .word_valid (word_valid),
      .word_data  (word_data),
      .word_ready (word_ready),
      .overflow   (overflow)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [19:0] gen(input int i);
      logic [31:0] v;
      v = (i + 1) * 32'h0009_E377 ^ 32'h000A_5C3B;
      return v[19:0];
   endfunction

   // driver: one cycle of stimulus plus the reference model
   task automatic step(input logic en, input logic hd, input logic md, input logic rdy, input logic [19:0] s);
      @(posedge clk);
      #2;
      enable = en; hold = hd; mode_trio = md; word_ready = rdy; sample_in = s;
      if (md != prev_mode) grp.delete();          // R7
      prev_mode = md;
      if (!en) begin
         grp.delete();                             // R6
      end else if (!hd) begin                      // R5: held samples never enter the group
         grp.push_back(s);
         if (md && grp.size() == 3) begin         // R2
            exp_q.push_back({grp[2][19:9], grp[1][19:9], grp[0][19:10]});
            tag_q.push_back("R2");
            grp.delete();
         end else if (!md && grp.size() == 2) begin // R3
            exp_q.push_back({grp[1][19:4], grp[0][19:4]});
            tag_q.push_back("R3");
            grp.delete();
         end
      end
      #1;
      chk(strobe == (en && !hd), "R1", {31'b0, strobe}, {31'b0, (en && !hd)});
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (word_valid) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4 unexpected word", word_data, 32'h0);
               end else begin
                  automatic logic [31:0] e = exp_q.pop_front();
                  automatic string t = tag_q.pop_front();
                  chk(word_data == e, t, word_data, e);
               end
            end
            chk(overflow == exp_ovf, "R8", {31'b0, overflow}, {31'b0, exp_ovf});
            if (word_valid && !word_ready) exp_ovf = 1'b1;
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; hold = 1'b0; mode_trio = 1'b1;
      word_ready = 1'b1; sample_in = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(word_valid == 1'b0, "R9", {31'b0, word_valid}, 32'h0);
      chk(overflow == 1'b0, "R9", {31'b0, overflow}, 32'h0);
      chk(strobe == 1'b0, "R6", {31'b0, strobe}, 32'h0);
      mon_on = 1'b1;

      // R2: back-to-back trio words
      for (int i = 0; i < 9; i++) step(1, 0, 1, 1, gen(i));
      // R5: trio with held cycles, leaves a partial group
      for (int i = 0; i < 12; i++) step(1, (i % 3 == 1), 1, 1, gen(i + 20));
      // R7: switch to pair mid-group; R3: pair words
      for (int i = 0; i < 8; i++) step(1, 0, 0, 1, gen(i + 40));
      // R5: pair with holds
      for (int i = 0; i < 10; i++) step(1, (i % 4 == 3), 0, 1, gen(i + 60));
      // R7: one pair slice, then back to trio
      step(1, 0, 0, 1, gen(80));
      for (int i = 0; i < 3; i++) step(1, 0, 1, 1, gen(i + 81));
      // R6: disable discards a partial trio group
      step(1, 0, 1, 1, gen(90));
      step(1, 0, 1, 1, gen(91));
      step(0, 0, 1, 1, gen(92));
      step(0, 1, 1, 1, gen(93));
      for (int i = 0; i < 3; i++) step(1, 0, 1, 1, gen(i + 94));
      // R6: disabled pair mode emits nothing
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, gen(i + 100));
      step(1, 0, 0, 1, gen(110));
      step(1, 0, 0, 1, gen(111));
      // R8: refused word sets sticky overflow
      for (int i = 0; i < 3; i++) step(1, 0, 1, 1, gen(i + 120));
      step(1, 1, 1, 0, gen(123));
      for (int i = 0; i < 4; i++) step(0, 0, 1, 1, gen(i + 124));
      @(negedge clk);
      chk(overflow == 1'b1, "R8 sticky", {31'b0, overflow}, 32'h1);
      // R4: every expected word arrived
      chk(exp_q.size() == 0, "R4 missing word", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule